// File: doc/BRIEF.md
# Shared Timer Bank Timeout Unit

This block gives a group of reaction channels timed sequence advance from one small bank of programmable 16-bit compare values. The host loads the bank entries and a common prescale ratio through a flat register port. When a channel moves to a new modulation word, it raises a start request together with the 2-bit bank index carried in that word. The request captures the selected compare value and arms a counter that belongs to that channel alone.

All channel counters step on a shared count-enable tick from a single prescaler. When a channel's counter reaches its captured value, the unit sends a one-cycle timeout to that channel only, and the counter clears and goes idle. The channel uses the timeout to fetch its next modulation word. Each bank entry has a configuration-error flag. The flag is raised when the entry's value, scaled by the prescale ratio, gives a counted time of 64 clocks or fewer, which is too short for sequence advance.

Top module: `stbk_timeout_unit`

## Requirements
- R1: After reset every register reads zero, and no channel is busy, timing out or flagging an index error.
- R2: Register addresses 0, 1 and 2 hold bank entries in bits 15:0. Address 3 holds the prescale field P in bits 7:0. All other bits read zero and ignore writes. Any other address reads zero, and writes to it are discarded.
- R3: A start request with index 0, 1 or 2 clears that channel's counter and captures the selected entry. The channel shows busy from the next cycle on.
- R4: With P = 0 and a captured value V ≥ 1, the timeout is high for exactly one cycle, V clock edges after the edge that sampled the start.
- R5: The counter advances once every P+1 clocks, so with P > 0 the timeout arrives between (V-1)(P+1)+1 and V(P+1) edges after the start.
- R6: On the timeout the channel drops busy and stays idle, with no further timeout, until a new start request.
- R7: A start request on a busy channel reloads its counter from zero. This also applies on the edge where the old count would have expired, and that old timeout is then dropped.
- R8: Channels count independently, and a timeout appears only on the channel that armed the counter.
- R9: A start request with index 3 changes neither the busy state nor the running count. It sets that channel's sticky index error, which only reset clears.
- R10: A captured value of zero times out on the first tick, the same as a value of one.
- R11: The configuration-error bit k is high while entry k × (P+1) ≤ 64 and low otherwise.
- R12: Rewriting a bank entry while a channel counts from it does not change that channel's running timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address, used for both read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| ch_start | input | NUM_CH | Start request, one bit per channel |
| ch_idx | input | NUM_CH*2 | Bank index per channel, channel n in bits 2n+1:2n |
| ch_timeout | output | NUM_CH | One-cycle timeout per channel |
| ch_busy | output | NUM_CH | Channel counter is armed |
| ch_idx_err | output | NUM_CH | Sticky flag for a start request with an invalid index |
| cfg_err | output | 3 | Per-entry flag for a counted time that is too short |

## Verification
Start requests and register writes are driven on a falling edge and sampled by the rising edge that follows. Busy, index error and read data are due at the next falling edge. The timeout is due V rising edges later when P = 0. With a larger P it falls inside a window whose position depends on the phase of the shared tick. The bench counts rising edges from the start edge and compares that count with V, or with the window bounds. It checks every channel's timeout on each falling edge in between, so early, late, doubled or misrouted pulses are all caught. The cases that hit the exact expiry cycle are set up by counting edges: a restart placed on the expiry edge, and a bank rewrite made while a count is running.

// File: rtl/stbk_pkg.sv
package stbk_pkg;

  localparam int STBK_DATA_W = 32;

  typedef enum logic {
    CH_IDLE = 1'b0,
    CH_RUN  = 1'b1
  } ch_state_e;

endpackage

// File: rtl/stbk_rst_sync.sv
module stbk_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/stbk_regbank.sv
module stbk_regbank #(
  parameter int BANK_N    = 3,
  parameter int TVAL_W    = 16,
  parameter int PSC_W     = 8,
  parameter int ADDR_W    = 3,
  parameter int DATA_W    = 32,
  parameter int MIN_TICKS = 64
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wen,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [DATA_W-1:0]        wdata,
  output logic [DATA_W-1:0]        rdata,
  output logic [BANK_N*TVAL_W-1:0] bank_flat,
  output logic [PSC_W-1:0]         psc_div,
  output logic [BANK_N-1:0]        cfg_err
);

  localparam int PSC_ADDR = BANK_N;
  localparam int PROD_W   = TVAL_W + PSC_W + 1;

  // Prescale ratio register
  logic             psc_wr;
  logic [PSC_W-1:0] psc_q;
  logic [PSC_W-1:0] psc_d;

  assign psc_wr = wen && (addr == ADDR_W'(PSC_ADDR));

  always_comb begin
    psc_d = psc_q;
    if (psc_wr) begin
      psc_d = wdata[PSC_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psc_q <= '0;
    end else begin
      psc_q <= psc_d;
    end
  end

  assign psc_div = psc_q;

  // Bank entries with their configuration checks
  for (genvar k = 0; k < BANK_N; k++) begin : g_entry
    logic              ent_wr;
    logic [TVAL_W-1:0] ent_q;
    logic [TVAL_W-1:0] ent_d;
    logic [PROD_W-1:0] scaled;

    assign ent_wr = wen && (addr == ADDR_W'(k));

    always_comb begin
      ent_d = ent_q;
      if (ent_wr) begin
        ent_d = wdata[TVAL_W-1:0];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_q <= '0;
      end else begin
        ent_q <= ent_d;
      end
    end

    // value * (P + 1) computed as value * P + value
    assign scaled = (PROD_W'(ent_q) * PROD_W'(psc_q)) + PROD_W'(ent_q);
    assign cfg_err[k] = (scaled <= PROD_W'(MIN_TICKS));
    assign bank_flat[k*TVAL_W +: TVAL_W] = ent_q;
  end

  // Read mux: unused bits and unmapped addresses return zero
  always_comb begin
    rdata = '0;
    for (int k = 0; k < BANK_N; k++) begin
      if (addr == ADDR_W'(k)) begin
        rdata[TVAL_W-1:0] = bank_flat[k*TVAL_W +: TVAL_W];
      end
    end
    if (addr == ADDR_W'(PSC_ADDR)) begin
      rdata[PSC_W-1:0] = psc_q;
    end
  end

endmodule

// File: rtl/stbk_prescaler.sv
module stbk_prescaler #(
  parameter int PSC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PSC_W-1:0] psc_div,
  output logic             tick
);

  logic [PSC_W-1:0] pcnt_q;
  logic [PSC_W-1:0] pcnt_d;

  // >= keeps the divider sane when the ratio is lowered mid-count
  assign tick = (pcnt_q >= psc_div);

  always_comb begin
    if (tick) begin
      pcnt_d = '0;
    end else begin
      pcnt_d = pcnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt_q <= '0;
    end else begin
      pcnt_q <= pcnt_d;
    end
  end

endmodule

// File: rtl/stbk_chan_ctr.sv
module stbk_chan_ctr
  import stbk_pkg::*;
#(
  parameter int BANK_N = 3,
  parameter int TVAL_W = 16,
  parameter int IDX_W  = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     tick,
  input  logic                     start,
  input  logic [IDX_W-1:0]         idx,
  input  logic [BANK_N*TVAL_W-1:0] bank_flat,
  output logic                     timeout,
  output logic                     busy,
  output logic                     idx_err
);

  ch_state_e         state_q, state_d;
  logic [TVAL_W-1:0] cnt_q, cnt_d;
  logic [TVAL_W-1:0] lim_q, lim_d;
  logic              tmo_q, tmo_d;
  logic              err_q, err_d;

  logic              idx_ok;
  logic              start_ok;
  logic [TVAL_W-1:0] sel_val;
  logic [TVAL_W-1:0] cnt_inc;
  logic              hit;

  assign idx_ok   = (idx < IDX_W'(BANK_N));
  assign start_ok = start && idx_ok;

  always_comb begin
    sel_val = '0;
    for (int k = 0; k < BANK_N; k++) begin
      if (idx == IDX_W'(k)) begin
        sel_val = bank_flat[k*TVAL_W +: TVAL_W];
      end
    end
  end

  assign cnt_inc = cnt_q + 1'b1;
  assign hit     = (cnt_inc >= lim_q);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    lim_d   = lim_q;
    tmo_d   = 1'b0;
    err_d   = err_q;

    if (start && !idx_ok) begin
      err_d = 1'b1;
    end

    if (start_ok) begin
      state_d = CH_RUN;
      cnt_d   = '0;
      lim_d   = sel_val;
    end else if ((state_q == CH_RUN) && tick) begin
      if (hit) begin
        state_d = CH_IDLE;
        cnt_d   = '0;
        tmo_d   = 1'b1;
      end else begin
        cnt_d   = cnt_inc;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CH_IDLE;
      cnt_q   <= '0;
      lim_q   <= '0;
      tmo_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      lim_q   <= lim_d;
      tmo_q   <= tmo_d;
      err_q   <= err_d;
    end
  end

  assign timeout = tmo_q;
  assign busy    = (state_q == CH_RUN);
  assign idx_err = err_q;

endmodule

// File: rtl/stbk_timeout_unit.sv
module stbk_timeout_unit
  import stbk_pkg::*;
#(
  parameter int NUM_CH    = 4,
  parameter int BANK_N    = 3,
  parameter int TVAL_W    = 16,
  parameter int PSC_W     = 8,
  parameter int ADDR_W    = 3,
  parameter int MIN_TICKS = 64,
  localparam int IDX_W    = $clog2(BANK_N + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    reg_wen,
  input  logic [ADDR_W-1:0]       reg_addr,
  input  logic [STBK_DATA_W-1:0]  reg_wdata,
  output logic [STBK_DATA_W-1:0]  reg_rdata,
  input  logic [NUM_CH-1:0]       ch_start,
  input  logic [NUM_CH*IDX_W-1:0] ch_idx,
  output logic [NUM_CH-1:0]       ch_timeout,
  output logic [NUM_CH-1:0]       ch_busy,
  output logic [NUM_CH-1:0]       ch_idx_err,
  output logic [BANK_N-1:0]       cfg_err
);

  logic                     rst_n_sync;
  logic [BANK_N*TVAL_W-1:0] bank_flat;
  logic [PSC_W-1:0]         psc_div;
  logic                     tick;

  stbk_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  stbk_regbank #(
    .BANK_N    (BANK_N),
    .TVAL_W    (TVAL_W),
    .PSC_W     (PSC_W),
    .ADDR_W    (ADDR_W),
    .DATA_W    (STBK_DATA_W),
    .MIN_TICKS (MIN_TICKS)
  ) u_regbank (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .wen       (reg_wen),
    .addr      (reg_addr),
    .wdata     (reg_wdata),
    .rdata     (reg_rdata),
    .bank_flat (bank_flat),
    .psc_div   (psc_div),
    .cfg_err   (cfg_err)
  );

  stbk_prescaler #(
    .PSC_W (PSC_W)
  ) u_prescaler (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .psc_div (psc_div),
    .tick    (tick)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    stbk_chan_ctr #(
      .BANK_N (BANK_N),
      .TVAL_W (TVAL_W),
      .IDX_W  (IDX_W)
    ) u_chan (
      .clk       (clk),
      .rst_n     (rst_n_sync),
      .tick      (tick),
      .start     (ch_start[c]),
      .idx       (ch_idx[c*IDX_W +: IDX_W]),
      .bank_flat (bank_flat),
      .timeout   (ch_timeout[c]),
      .busy      (ch_busy[c]),
      .idx_err   (ch_idx_err[c])
    );
  end

endmodule

// File: rtl/stbk_checker.sv
module stbk_checker #(
  parameter int NUM_CH = 4,
  parameter int BANK_N = 3,
  parameter int TVAL_W = 16,
  parameter int IDX_W  = 2,
  parameter int DATA_W = 32
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [NUM_CH-1:0]       ch_start,
  input logic [NUM_CH*IDX_W-1:0] ch_idx,
  input logic [NUM_CH-1:0]       ch_timeout,
  input logic [NUM_CH-1:0]       ch_busy,
  input logic [NUM_CH-1:0]       ch_idx_err,
  input logic [DATA_W-1:0]       reg_rdata
);

  // R2
  rdata_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[DATA_W-1:TVAL_W] == '0);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    logic idx_valid;
    assign idx_valid = (ch_idx[c*IDX_W +: IDX_W] < IDX_W'(BANK_N));

    // R3
    start_arms_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_start[c] && idx_valid) |=> (ch_busy[c] && !ch_timeout[c]));

    // R4
    timeout_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ch_timeout[c] |=> !ch_timeout[c]);

    // R6
    timeout_ends_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ch_timeout[c] |-> (!ch_busy[c] && $past(ch_busy[c])));

    // R9
    bad_idx_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_start[c] && !idx_valid && !ch_busy[c]) |=> (!ch_busy[c] && ch_idx_err[c]));

    // R9
    idx_err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ch_idx_err[c] |=> ch_idx_err[c]);
  end

endmodule

bind stbk_timeout_unit stbk_checker #(
  .NUM_CH (NUM_CH),
  .BANK_N (BANK_N),
  .TVAL_W (TVAL_W),
  .IDX_W  (IDX_W),
  .DATA_W (stbk_pkg::STBK_DATA_W)
) u_stbk_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .ch_start   (ch_start),
  .ch_idx     (ch_idx),
  .ch_timeout (ch_timeout),
  .ch_busy    (ch_busy),
  .ch_idx_err (ch_idx_err),
  .reg_rdata  (reg_rdata)
);

// File: tb/test_stbk_timeout_unit.sv
module test_stbk_timeout_unit;

  localparam int NCH = 4;

  logic        clk;
  logic        rst_n;
  logic        reg_wen;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [3:0]  ch_start;
  logic [7:0]  ch_idx;
  logic [3:0]  ch_timeout;
  logic [3:0]  ch_busy;
  logic [3:0]  ch_idx_err;
  logic [2:0]  cfg_err;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  bit done   = 0;

  stbk_timeout_unit i_stbk_timeout_unit (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wen    (reg_wen),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .ch_start   (ch_start),
    .ch_idx     (ch_idx),
    .ch_timeout (ch_timeout),
    .ch_busy    (ch_busy),
    .ch_idx_err (ch_idx_err),
    .cfg_err    (cfg_err)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; reg_wen = 1'b0; reg_addr = '0; reg_wdata = '0;
    ch_start = '0; ch_idx = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wen = 1'b1;
    @(negedge clk);
    reg_wen = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic pulse_start(input int ch, input logic [1:0] ix, output int t0);
    ch_start[ch] = 1'b1;
    ch_idx[ch*2 +: 2] = ix;
    @(negedge clk);
    ch_start[ch] = 1'b0;
    t0 = cyc;
  endtask

  // waits for the channel's timeout; returns edges since start and any other channel's pulses
  task automatic wait_tmo(input int ch, input int t0, input int limit,
                          output int d, output logic [3:0] others);
    others = '0;
    d = -1;
    for (int n = 0; n < limit; n++) begin
      @(negedge clk);
      others |= ch_timeout & ~(4'b1 << ch);
      if (ch_timeout[ch]) begin
        d = cyc - t0;
        break;
      end
    end
  endtask

  task automatic t_reset();
    logic [31:0] rd;
    do_reset();
    for (int a = 0; a < 8; a++) begin
      reg_read(3'(a), rd);
      chk(rd == 0, "R1 reset register", rd, 0);
    end
    chk(ch_busy == 0, "R1 reset busy", ch_busy, 0);
    chk(ch_timeout == 0, "R1 reset timeout", ch_timeout, 0);
    chk(ch_idx_err == 0, "R1 reset idx_err", ch_idx_err, 0);
    chk(cfg_err == 3'b111, "R11 reset cfg_err", cfg_err, 7);
  endtask

  task automatic t_regs();
    logic [31:0] rd;
    do_reset();
    reg_write(3'd0, 32'hABCD_0041);
    reg_read(3'd0, rd);
    chk(rd == 32'h41, "R2 entry low half", rd, 32'h41);
    reg_write(3'd2, 32'h0000_BEEF);
    reg_read(3'd2, rd);
    chk(rd == 32'hBEEF, "R2 entry 2", rd, 32'hBEEF);
    reg_write(3'd3, 32'hFFFF_FF05);
    reg_read(3'd3, rd);
    chk(rd == 32'h05, "R2 prescale field", rd, 5);
    reg_write(3'd5, 32'h0000_1234);
    reg_read(3'd5, rd);
    chk(rd == 0, "R2 unmapped read", rd, 0);
    reg_read(3'd0, rd);
    chk(rd == 32'h41, "R2 unmapped write discarded", rd, 32'h41);
    reg_read(3'd1, rd);
    chk(rd == 0, "R2 entry 1 untouched", rd, 0);
  endtask

  task automatic t_basic();
    int t0, d;
    logic [3:0] oth;
    do_reset();
    reg_write(3'd0, 32'd7);
    reg_write(3'd1, 32'd1);
    pulse_start(1, 2'd0, t0);
    chk(ch_busy == 4'b0010, "R3 busy after start", ch_busy, 4'b0010);
    wait_tmo(1, t0, 50, d, oth);
    chk(d == 7, "R4 timeout edge V=7", d, 7);
    chk(oth == 0, "R8 no stray timeout", oth, 0);
    chk(ch_busy[1] == 1'b0, "R6 busy drops at timeout", ch_busy[1], 0);
    @(negedge clk);
    chk(ch_timeout[1] == 1'b0, "R4 one-cycle pulse", ch_timeout[1], 0);
    oth = '0;
    for (int n = 0; n < 20; n++) begin
      @(negedge clk);
      oth |= ch_timeout | ch_busy;
    end
    chk(oth == 0, "R6 stays idle", oth, 0);
    pulse_start(3, 2'd1, t0);
    wait_tmo(3, t0, 20, d, oth);
    chk(d == 1, "R4 timeout edge V=1", d, 1);
  endtask

  task automatic t_zero();
    int t0, d;
    logic [3:0] oth;
    do_reset();
    pulse_start(0, 2'd2, t0);
    wait_tmo(0, t0, 20, d, oth);
    chk(d == 1, "R10 zero value first tick", d, 1);
  endtask

  task automatic t_restart();
    int t0, d;
    logic [3:0] seen;
    logic [3:0] oth;
    do_reset();
    reg_write(3'd0, 32'd10);
    pulse_start(2, 2'd0, t0);
    seen = '0;
    while (cyc - t0 < 9) begin
      @(negedge clk);
      seen |= ch_timeout;
    end
    chk(seen == 0, "R7 no early timeout", seen, 0);
    pulse_start(2, 2'd0, t0);
    wait_tmo(2, t0, 40, d, oth);
    chk(d == 10, "R7 restart on expiry edge reloads", d, 10);
  endtask

  task automatic t_indep();
    int ta, tb, d;
    logic [3:0] oth;
    do_reset();
    reg_write(3'd0, 32'd3);
    reg_write(3'd2, 32'd9);
    pulse_start(0, 2'd0, ta);
    pulse_start(2, 2'd2, tb);
    chk(ch_busy == 4'b0101, "R8 both busy", ch_busy, 4'b0101);
    wait_tmo(0, ta, 20, d, oth);
    chk(d == 3, "R8 channel 0 timeout", d, 3);
    chk(oth == 0, "R8 only channel 0 pulses", oth, 0);
    chk(ch_busy == 4'b0100, "R8 channel 2 still busy", ch_busy, 4'b0100);
    wait_tmo(2, tb, 20, d, oth);
    chk(d == 9, "R8 channel 2 timeout", d, 9);
    chk(oth == 0, "R8 only channel 2 pulses", oth, 0);
  endtask

  task automatic t_badidx();
    int t0, d, tx;
    logic [3:0] oth;
    do_reset();
    reg_write(3'd0, 32'd3);
    pulse_start(1, 2'd3, t0);
    chk(ch_busy == 0, "R9 bad index stays idle", ch_busy, 0);
    chk(ch_idx_err == 4'b0010, "R9 index error set", ch_idx_err, 4'b0010);
    pulse_start(1, 2'd0, t0);
    wait_tmo(1, t0, 20, d, oth);
    chk(d == 3, "R9 channel still usable", d, 3);
    chk(ch_idx_err[1] == 1'b1, "R9 index error sticky", ch_idx_err[1], 1);
    pulse_start(3, 2'd0, t0);
    pulse_start(3, 2'd3, tx);
    chk(ch_busy[3] == 1'b1, "R9 bad index keeps run", ch_busy[3], 1);
    wait_tmo(3, t0, 20, d, oth);
    chk(d == 3, "R9 bad index no reload", d, 3);
    chk(ch_idx_err == 4'b1010, "R9 error bits per channel", ch_idx_err, 4'b1010);
  endtask

  task automatic t_latch();
    int t0, d;
    logic [3:0] oth;
    do_reset();
    reg_write(3'd1, 32'd20);
    pulse_start(0, 2'd1, t0);
    reg_write(3'd1, 32'd2);
    wait_tmo(0, t0, 60, d, oth);
    chk(d == 20, "R12 captured value kept", d, 20);
  endtask

  task automatic t_psc();
    int t0, d;
    logic [3:0] oth;
    do_reset();
    reg_write(3'd3, 32'd3);
    reg_write(3'd0, 32'd5);
    for (int r = 0; r < 3; r++) begin
      pulse_start(0, 2'd0, t0);
      wait_tmo(0, t0, 60, d, oth);
      chk(d >= 17 && d <= 20, "R5 prescaled window", d, 17);
      repeat (r + 1) @(negedge clk);
    end
  endtask

  task automatic t_cfg();
    do_reset();
    reg_write(3'd0, 32'd65);
    chk(cfg_err[0] == 1'b0, "R11 65 ticks ok", cfg_err[0], 0);
    reg_write(3'd0, 32'd64);
    chk(cfg_err[0] == 1'b1, "R11 64 ticks flagged", cfg_err[0], 1);
    reg_write(3'd3, 32'd1);
    reg_write(3'd1, 32'd32);
    chk(cfg_err[1] == 1'b1, "R11 32x2 flagged", cfg_err[1], 1);
    chk(cfg_err[0] == 1'b0, "R11 64x2 ok", cfg_err[0], 0);
    reg_write(3'd1, 32'd33);
    chk(cfg_err[1] == 1'b0, "R11 33x2 ok", cfg_err[1], 0);
    chk(cfg_err[2] == 1'b1, "R11 zero entry flagged", cfg_err[2], 1);
  endtask

  initial begin
    t_reset();
    t_regs();
    t_basic();
    t_zero();
    t_restart();
    t_indep();
    t_badidx();
    t_latch();
    t_psc();
    t_cfg();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=0x0 expected=0x1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule